// File: doc/BRIEF.md
# Two-Cluster Memory Request Arbiter

This block chooses, every clock cycle, which of several threads may send its pending memory request onward. It splits the threads into two groups according to how memory-hungry they were recently. Threads that miss rarely form the light group, and they always win over the heavy group. Within the light group the order is fixed by intensity, which favours throughput. Within the heavy group the order rotates on a short timer, so each heavy thread in turn gets the top slot, which favours fairness.

Intensity is measured per thread as misses per thousand retired instructions, using one miss strobe and one retire strobe per thread. It is evaluated over a fixed-length quantum. At the end of a quantum the block latches the new figures and the group membership, then clears its counters. A threshold input picks the split. A higher threshold moves more threads into the strictly ranked light group and raises throughput. A lower threshold moves more threads into the rotating group and improves fairness.

Top module: `mem_cluster_arb`

## Requirements
- R1: At the end of each quantum, a thread's intensity is floor(misses * 1000 / retired instructions), clamped to the maximum value the intensity field can hold. A thread with no retired instructions gets 0 if it had no misses, and the maximum value otherwise.
- R2: The counts of one quantum govern arbitration only during the following quantum. The counters restart at every quantum boundary, so a quantum with no events leaves every thread at intensity 0.
- R3: At a quantum boundary, a thread becomes light when its intensity is less than or equal to `clusterThresh`, and heavy otherwise. The threshold is sampled only at the boundary, so changing it mid-quantum has no effect until the next boundary.
- R4: Any requesting light thread wins over every requesting heavy thread.
- R5: Among light threads, lower intensity wins. Equal intensity goes to the lower thread index.
- R6: Among heavy threads, the winner is the one with the smallest (index − rot) mod NUM_THREADS. The offset rot is 0 after reset and advances by one, wrapping, at the end of every SHUFFLE_CYCLES cycles.
- R7: `grant` is one-hot on the winning requester and `grantValid` is high when any request is valid. With no request, both are zero. The result is combinational in the same cycle as `reqValid`.
- R8: After reset, every thread has intensity 0 and is light, so the lowest requesting index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | NUM_THREADS | Per-thread pending request |
| missPulse | input | NUM_THREADS | Per-thread one-cycle miss event |
| retirePulse | input | NUM_THREADS | Per-thread one-cycle instruction-retired event |
| clusterThresh | input | MPKI_W | Light/heavy split threshold, in misses per thousand instructions |
| grant | output | NUM_THREADS | One-hot grant |
| grantValid | output | 1 | A grant is given this cycle |

## Verification
The bench aims at the threshold boundary: a thread sitting exactly at the threshold must be light. A design that used a strict comparison would rotate that thread among the heavy ones. It also checks an intensity of 33.3, which must floor to 33. A design that rounded up would push that thread into the heavy group, where it loses to a rotating peer. The bench sweeps the rotation offset across all four values with two heavy requesters, so an off-by-one rotation or a wrong direction hands the grant to the wrong thread. Other checks cover equal-intensity ties, threads with zero retired instructions, a threshold changed in the middle of a quantum, and an empty quantum. These catch, in turn, tie-breaking toward the wrong index, division by zero, a threshold applied before the boundary, and counters that are not cleared.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef struct packed {
    logic quantumEnd;   // last cycle of the measurement quantum
    logic shuffleStep;  // last cycle of a shuffle interval
  } arbStrobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int QUANTUM_CYCLES = 128,
  parameter int SHUFFLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  output arbStrobe_t strobes
);
  localparam int QW = (QUANTUM_CYCLES > 2) ? $clog2(QUANTUM_CYCLES) : 1;
  localparam int SW = (SHUFFLE_CYCLES > 2) ? $clog2(SHUFFLE_CYCLES) : 1;

  logic [QW-1:0] qCnt;
  logic [SW-1:0] sCnt;
  logic qLast, sLast;

  assign qLast = (qCnt == QW'(QUANTUM_CYCLES - 1));
  assign sLast = (sCnt == SW'(SHUFFLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      qCnt <= '0;
      sCnt <= '0;
    end else begin
      qCnt <= qLast ? '0 : qCnt + 1'b1;
      sCnt <= sLast ? '0 : sCnt + 1'b1;
    end
  end

  assign strobes.quantumEnd  = qLast;
  assign strobes.shuffleStep = sLast;
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 12,
  parameter int MPKI_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  arbStrobe_t             strobes,
  input  logic [NUM_THREADS-1:0] reqValid,
  input  logic [NUM_THREADS-1:0] missPulse,
  input  logic [NUM_THREADS-1:0] retirePulse,
  input  logic [MPKI_W-1:0]      clusterThresh,
  output logic [NUM_THREADS-1:0] grant,
  output logic                   grantValid,
  output logic [NUM_THREADS-1:0] heavyMask,
  output logic [$clog2(NUM_THREADS)-1:0] rotOffset
);
  localparam int IDX_W  = $clog2(NUM_THREADS);
  localparam int PROD_W = CNT_W + 10;
  localparam int KEY_W  = 1 + MPKI_W + IDX_W;
  localparam logic [PROD_W-1:0] MPKI_MAX = PROD_W'({MPKI_W{1'b1}});

  logic [CNT_W-1:0]  missCnt [NUM_THREADS];
  logic [CNT_W-1:0]  instCnt [NUM_THREADS];
  logic [MPKI_W-1:0] mpkiNew [NUM_THREADS];
  logic [MPKI_W-1:0] mpkiReg [NUM_THREADS];
  logic [KEY_W-1:0]  rankKey [NUM_THREADS];

  // per-quantum event counters, restarted at the boundary
  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (rst) begin
        missCnt[t] <= '0;
        instCnt[t] <= '0;
      end else if (strobes.quantumEnd) begin
        missCnt[t] <= CNT_W'(missPulse[t]);
        instCnt[t] <= CNT_W'(retirePulse[t]);
      end else begin
        if (missPulse[t] && missCnt[t] != '1)   missCnt[t] <= missCnt[t] + 1'b1;
        if (retirePulse[t] && instCnt[t] != '1) instCnt[t] <= instCnt[t] + 1'b1;
      end
    end
  end

  // intensity for the quantum now ending
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [PROD_W-1:0] prod, divisor, quot;
      prod    = PROD_W'(missCnt[t]) * PROD_W'(1000);
      divisor = (instCnt[t] == '0) ? PROD_W'(1) : PROD_W'(instCnt[t]);
      quot    = prod / divisor;
      if (instCnt[t] == '0)
        mpkiNew[t] = (missCnt[t] == '0) ? '0 : '1;
      else if (quot > MPKI_MAX)
        mpkiNew[t] = '1;
      else
        mpkiNew[t] = quot[MPKI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heavyMask <= '0;
      for (int t = 0; t < NUM_THREADS; t++) mpkiReg[t] <= '0;
    end else if (strobes.quantumEnd) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        mpkiReg[t]   <= mpkiNew[t];
        heavyMask[t] <= (mpkiNew[t] > clusterThresh);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rotOffset <= '0;
    else if (strobes.shuffleStep)
      rotOffset <= (rotOffset == IDX_W'(NUM_THREADS - 1)) ? '0 : rotOffset + 1'b1;
  end

  // ranking key: smaller wins; index in the low bits breaks exact ties
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [IDX_W:0] sum;
      sum = {1'b0, IDX_W'(t)} + (IDX_W+1)'(NUM_THREADS) - {1'b0, rotOffset};
      if (sum >= (IDX_W+1)'(NUM_THREADS)) sum = sum - (IDX_W+1)'(NUM_THREADS);
      rankKey[t] = {heavyMask[t],
                    heavyMask[t] ? MPKI_W'(sum[IDX_W-1:0]) : mpkiReg[t],
                    IDX_W'(t)};
    end
  end

  always_comb begin
    logic [KEY_W-1:0] bestKey;
    logic [IDX_W-1:0] bestIdx;
    logic found;
    found   = 1'b0;
    bestKey = '1;
    bestIdx = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (reqValid[t] && (!found || rankKey[t] < bestKey)) begin
        found   = 1'b1;
        bestKey = rankKey[t];
        bestIdx = IDX_W'(t);
      end
    end
    grantValid = found;
    grant      = found ? (NUM_THREADS'(1) << bestIdx) : '0;
  end
endmodule

// File: rtl/mem_cluster_arb.sv
module mem_cluster_arb
  import arb_pkg::*;
#(
  parameter int NUM_THREADS    = 4,
  parameter int CNT_W          = 12,
  parameter int MPKI_W         = 16,
  parameter int QUANTUM_CYCLES = 128,
  parameter int SHUFFLE_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] reqValid,
  input  logic [NUM_THREADS-1:0] missPulse,
  input  logic [NUM_THREADS-1:0] retirePulse,
  input  logic [MPKI_W-1:0]      clusterThresh,
  output logic [NUM_THREADS-1:0] grant,
  output logic                   grantValid
);
  arbStrobe_t strobes;
  logic [NUM_THREADS-1:0] heavyMask;
  logic [$clog2(NUM_THREADS)-1:0] rotOffset;

  arb_ctrl #(.QUANTUM_CYCLES(QUANTUM_CYCLES), .SHUFFLE_CYCLES(SHUFFLE_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .strobes(strobes));

  arb_datapath #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .MPKI_W(MPKI_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .reqValid(reqValid),
    .missPulse(missPulse), .retirePulse(retirePulse), .clusterThresh(clusterThresh),
    .grant(grant), .grantValid(grantValid), .heavyMask(heavyMask), .rotOffset(rotOffset));
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_THREADS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_THREADS-1:0] reqValid,
  input logic [NUM_THREADS-1:0] grant,
  input logic                   grantValid,
  input logic [NUM_THREADS-1:0] heavyMask,
  input logic                   quantumEnd,
  input logic [$clog2(NUM_THREADS)-1:0] rotOffset
);
  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R7
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~reqValid) == '0);
  // R7
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid == '0) |-> (!grantValid && grant == '0));
  // R4
  light_first_chk: assert property (@(posedge clk) disable iff (rst)
    ((grant & heavyMask) != '0) |-> ((reqValid & ~heavyMask) == '0));
  // R3
  cluster_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !quantumEnd |=> $stable(heavyMask));
  // R6
  rot_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rotOffset == $past(rotOffset)) ||
             (rotOffset == (($past(rotOffset) == ($clog2(NUM_THREADS))'(NUM_THREADS - 1))
                            ? '0 : $past(rotOffset) + 1'b1)));
endmodule

bind mem_cluster_arb arb_checker #(.NUM_THREADS(NUM_THREADS)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .grant(grant), .grantValid(grantValid),
  .heavyMask(heavyMask), .quantumEnd(strobes.quantumEnd), .rotOffset(rotOffset));

// File: tb/mem_cluster_arb_tb.sv
module mem_cluster_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int QUANT = 128;
  localparam int SHUF = 16;
  localparam int MAXV = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] reqValid = '0, missPulse = '0, retirePulse = '0;
  logic [15:0] clusterThresh = 16'd40;
  logic [NT-1:0] grant;
  logic grantValid;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int modelMpki [NT];
  bit modelHeavy [NT];
  int pendMpki [NT];
  bit pendHeavy [NT];

  typedef struct { bit v; int idx; string tag; } item_t;
  item_t sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_cluster_arb #(.NUM_THREADS(NT), .QUANTUM_CYCLES(QUANT), .SHUFFLE_CYCLES(SHUF)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .missPulse(missPulse),
    .retirePulse(retirePulse), .clusterThresh(clusterThresh),
    .grant(grant), .grantValid(grantValid));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  function automatic int calcMpki(int m, int i);
    int q;
    if (i == 0) return (m == 0) ? 0 : MAXV;
    q = m * 1000 / i;
    return (q > MAXV) ? MAXV : q;
  endfunction

  function automatic int expGrant(logic [NT-1:0] req, int rot);
    longint best = -1, key;
    int idx = -1;
    for (int t = 0; t < NT; t++) begin
      if (req[t]) begin
        key = modelHeavy[t] ? (longint'(1) << 40) + ((t - rot + NT) % NT) : modelMpki[t];
        key = key * 16 + t;
        if (best < 0 || key < best) begin best = key; idx = t; end
      end
    end
    return idx;
  endfunction

  task automatic atOffset(int off);
    @(negedge clk);
    while (cyc % QUANT != off) @(negedge clk);
  endtask

  // driver: set requests at an offset and push the expected winner
  task automatic drive(int off, logic [NT-1:0] req, string tag);
    item_t it;
    int e;
    atOffset(off);
    reqValid = req;
    e = expGrant(req, (off / SHUF) % NT);
    it.v = (e >= 0); it.idx = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare outputs after the driver settles
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [NT-1:0] expG;
      it = sb.pop_front();
      expG = it.v ? (NT'(1) << it.idx) : '0;
      checks++;
      if (grantValid !== it.v || grant !== expG) begin
        errors++;
        $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                 it.tag, grant, grantValid, expG, it.v);
      end
    end
  end

  task automatic runEvents(int thr, int m0, int i0, int m1, int i1, int m2, int i2, int m3, int i3);
    int ms [NT], is [NT];
    ms = '{m0, m1, m2, m3}; is = '{i0, i1, i2, i3};
    atOffset(63);
    reqValid = '0;
    clusterThresh = 16'(thr);
    for (int t = 0; t < NT; t++) begin
      pendMpki[t]  = calcMpki(ms[t], is[t]);
      pendHeavy[t] = pendMpki[t] > thr;
    end
    for (int k = 0; k < 50; k++) begin
      atOffset(64 + k);
      for (int t = 0; t < NT; t++) begin
        missPulse[t]   = (k < ms[t]);
        retirePulse[t] = (k < is[t]);
      end
    end
    atOffset(114);
    missPulse = '0; retirePulse = '0;
  endtask

  task automatic commit();
    for (int t = 0; t < NT; t++) begin
      modelMpki[t] = pendMpki[t]; modelHeavy[t] = pendHeavy[t];
    end
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin
      modelMpki[t] = 0; modelHeavy[t] = 0; pendMpki[t] = 0; pendHeavy[t] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (grant !== '0 && grantValid !== 1'b0) begin
      errors++; $display("FAIL R7 reset idle: grant=%b expected 0", grant);
    end
    rst = 1'b0;
    // quantum 0: reset state
    drive(4, 4'b1111, "R8 reset ranks index 0 first");
    drive(6, 4'b0000, "R7 no request no grant");
    drive(20, 4'b1100, "R8 lowest requester wins");
    runEvents(40, 3, 50, 1, 50, 4, 50, 2, 50);
    // quantum 1: mpki {60,20,80,40}, thread 3 exactly at threshold
    atOffset(0); commit();
    drive(4, 4'b1111, "R5 lowest intensity light wins");
    drive(6, 4'b1101, "R3 at-threshold thread is light");
    drive(8, 4'b0101, "R6 rot0 heavy order");
    drive(24, 4'b0101, "R6 rot1 heavy order");
    drive(40, 4'b0101, "R6 rot2 heavy order");
    drive(56, 4'b0101, "R6 rot3 heavy order");
    drive(58, 4'b1100, "R4 light beats heavy");
    runEvents(39, 3, 50, 1, 50, 4, 50, 2, 50);
    // quantum 2: thread 3 now heavy
    atOffset(0); commit();
    drive(4, 4'b1001, "R3 threshold below intensity makes heavy");
    atOffset(6); clusterThresh = 16'd1000;
    drive(24, 4'b0101, "R3 mid-quantum threshold ignored");
    drive(26, 4'b1010, "R4 light t1 over heavy t3");
    runEvents(33, 3, 0, 1, 30, 0, 0, 1, 30);
    // quantum 3: zero-instruction and floor cases
    atOffset(0); commit();
    drive(4, 4'b1111, "R1 zero instructions zero misses is 0");
    drive(6, 4'b1010, "R5 equal intensity lower index");
    drive(8, 4'b0011, "R1 floor keeps 33 light, zero-instr misses heavy");
    drive(10, 4'b0001, "R7 single heavy requester");
    // quantum 4: empty previous quantum
    atOffset(0);
    for (int t = 0; t < NT; t++) begin pendMpki[t] = 0; pendHeavy[t] = 0; end
    commit();
    drive(4, 4'b1111, "R2 counters restarted, all zero");
    drive(6, 4'b1010, "R2 all light after empty quantum");
    atOffset(8); reqValid = '0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule